// File: doc/BRIEF.md
# Packed-Control Bit Field Extractor

This block pulls a contiguous run of bits out of a data operand and returns it right-aligned, with every bit above the run cleared. The run is described by one control word. Its low byte gives the index of the first bit taken, and the byte above that gives how many bits are taken. The field covers positions from the start index up to, but not including, start plus length. A mode input chooses whether the operand is treated as 32 or 64 bits wide.

Requests may arrive on every cycle. Each accepted request produces a registered result one clock later, together with a valid strobe and a flag that is high when the result is all zeros. Start and length values that do not fit the operand saturate instead of wrapping. A start at or beyond the operand width, or a length of zero, gives zero. A field that runs past the top of the operand is cut off at the top bit.

Top module: `bfx_unit`

## Requirements
- R1: While reset is high, and on the first cycle after it, out_valid, out_field and out_zero are all 0.
- R2: For an accepted request, bit i of the result equals operand bit start+i when i < length and start+i < width, where start is in_ctrl[7:0], length is in_ctrl[15:8], and width is 64 when in_wide=1 and 32 when in_wide=0. Every other result bit is 0. Example: operand 0x50 with start 4 and length 4 gives 0x5.
- R3: When start is greater than or equal to the width, the result is 0 and out_zero is 1.
- R4: When length is 0, the result is 0 and out_zero is 1.
- R5: When start plus length exceeds the width, only the operand bits from start up to width-1 are returned. Length values up to 255 are accepted and never wrap.
- R6: When in_wide=0, out_field[63:32] is 0, and in_data[63:32] has no effect on the result.
- R7: in_ctrl bits 31 down to 16 have no effect on the result.
- R8: out_valid is high in the cycle after a cycle with in_valid high, and low in the cycle after a cycle with in_valid low.
- R9: Whenever out_valid is high, out_zero is 1 exactly when out_field is 0.
- R10: In a cycle with in_valid low, out_field and out_zero keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe, may be high every cycle |
| in_wide | input | 1 | 1 = 64-bit operand, 0 = 32-bit operand |
| in_data | input | 64 | Data operand |
| in_ctrl | input | 32 | Control word: [7:0] start, [15:8] length, upper bits unused |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_field | output | 64 | Extracted field, right-aligned, upper bits zero |
| out_zero | output | 1 | High when out_field is zero |

## Verification
Top-of-operand clipping and narrow-mode blanking can act on the same request. This happens in 32-bit mode when start plus length runs past bit 31 and the operand has bits set above bit 31. The bench drives that case with every bit of in_data set and checks two things. The result must stop at operand bit 31, and the bits that would have come from in_data[63:32] must read as zero. A second kind of coincidence is a saturated request that produces zero on the cycle straight after a non-zero result. There the bench checks out_field and out_zero together in that cycle, so a stale field or a stale zero flag shows up as a miscompare.

// File: rtl/bfx_pkg.sv
package bfx_pkg;

    localparam int BFX_DATA_W   = 64;
    localparam int BFX_NARROW_W = 32;
    localparam int BFX_CTRL_W   = 32;
    localparam int BFX_IDX_W    = 8;

    typedef enum logic {
        MODE_NARROW = 1'b0,
        MODE_WIDE   = 1'b1
    } width_mode_t;

    // packed so that length sits above start, as in the control word
    typedef struct packed {
        logic [BFX_IDX_W-1:0] len;
        logic [BFX_IDX_W-1:0] start;
    } fld_ctrl_t;

    typedef struct packed {
        logic [BFX_DATA_W-1:0] field;
        logic                  zero;
    } fld_result_t;

    function automatic logic is_wide(input width_mode_t m);
        return m == MODE_WIDE;
    endfunction

endpackage

// File: rtl/bfx_ctrl_unpack.sv
module bfx_ctrl_unpack
    import bfx_pkg::*;
#(
    parameter int CTRL_W = BFX_CTRL_W
) (
    input  logic [CTRL_W-1:0] ctrl,
    output fld_ctrl_t         fld
);
    localparam int USED_W = 2 * BFX_IDX_W;

    assign fld = fld_ctrl_t'(ctrl[USED_W-1:0]);

    generate
        if (CTRL_W > USED_W) begin : g_spare
            logic unused_hi;
            assign unused_hi = ^ctrl[CTRL_W-1:USED_W];
        end
    endgenerate
endmodule

// File: rtl/bfx_operand_prep.sv
module bfx_operand_prep
    import bfx_pkg::*;
#(
    parameter int DATA_W   = BFX_DATA_W,
    parameter int NARROW_W = BFX_NARROW_W
) (
    input  logic [DATA_W-1:0] data,
    input  width_mode_t       mode,
    output logic [DATA_W-1:0] operand
);
    logic keep_hi;
    assign keep_hi = is_wide(mode);

    genvar i;
    generate
        for (i = 0; i < DATA_W; i++) begin : g_bit
            if (i < NARROW_W) begin : g_lo
                assign operand[i] = data[i];
            end else begin : g_hi
                assign operand[i] = data[i] & keep_hi;
            end
        end
    endgenerate
endmodule

// File: rtl/bfx_field_core.sv
module bfx_field_core
    import bfx_pkg::*;
#(
    parameter int DATA_W = BFX_DATA_W
) (
    input  logic [DATA_W-1:0] operand,
    input  fld_ctrl_t         fld,
    output fld_result_t       res
);
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] mask;

    // operand upper bits are already zero in narrow mode, so a shift past the
    // active width brings in only zeros: that gives start and top saturation
    assign shifted = operand >> fld.start;

    genvar i;
    generate
        for (i = 0; i < DATA_W; i++) begin : g_mask
            if (i < (1 << BFX_IDX_W)) begin : g_cmp
                assign mask[i] = fld.len > BFX_IDX_W'(i);
            end else begin : g_none
                assign mask[i] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        res.field = shifted & mask;
        res.zero  = ~|res.field;
    end
endmodule

// File: rtl/bfx_out_stage.sv
module bfx_out_stage
    import bfx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  fld_result_t res_d,
    output logic        out_valid,
    output fld_result_t res_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            res_q     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_q <= res_d;
            end
        end
    end
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
    import bfx_pkg::*;
#(
    parameter int DATA_W   = BFX_DATA_W,
    parameter int NARROW_W = BFX_NARROW_W,
    parameter int CTRL_W   = BFX_CTRL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_wide,
    input  logic [DATA_W-1:0] in_data,
    input  logic [CTRL_W-1:0] in_ctrl,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_field,
    output logic              out_zero
);
    fld_ctrl_t         fld;
    logic [DATA_W-1:0] operand;
    fld_result_t       res_d;
    fld_result_t       res_q;
    width_mode_t       mode;

    assign mode = width_mode_t'(in_wide);

    bfx_ctrl_unpack #(.CTRL_W(CTRL_W)) u_unpack (
        .ctrl (in_ctrl),
        .fld  (fld)
    );

    bfx_operand_prep #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_prep (
        .data    (in_data),
        .mode    (mode),
        .operand (operand)
    );

    bfx_field_core #(.DATA_W(DATA_W)) u_core (
        .operand (operand),
        .fld     (fld),
        .res     (res_d)
    );

    bfx_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .res_d     (res_d),
        .out_valid (out_valid),
        .res_q     (res_q)
    );

    assign out_field = res_q.field;
    assign out_zero  = res_q.zero;
endmodule

// File: rtl/bfx_checker.sv
module bfx_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_wide,
    input logic [31:0] in_ctrl,
    input logic        out_valid,
    input logic [63:0] out_field,
    input logic        out_zero
);
    logic start_oob;
    assign start_oob = in_ctrl[7:0] >= (in_wide ? 8'd64 : 8'd32);

    assert_valid_follow_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_valid_drop_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_zero_flag_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_zero == (out_field == 64'd0)));

    assert_narrow_upper_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_wide) |=> (out_field[63:32] == 32'd0));

    assert_start_oob_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && start_oob) |=> (out_zero && out_field == 64'd0));

    assert_len_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ctrl[15:8] == 8'd0) |=> (out_zero && out_field == 64'd0));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_field) && $stable(out_zero)));
endmodule

bind bfx_unit bfx_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_wide   (in_wide),
    .in_ctrl   (in_ctrl),
    .out_valid (out_valid),
    .out_field (out_field),
    .out_zero  (out_zero)
);

// File: tb/sim_bfx_unit.sv
`timescale 1ns/1ps
module sim_bfx_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_wide;
    logic [63:0] in_data;
    logic [31:0] in_ctrl;
    logic        out_valid;
    logic [63:0] out_field;
    logic        out_zero;

    int vectors = 0;
    int miscompares = 0;

    always #2.5 clk = ~clk;

    bfx_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_wide(in_wide),
        .in_data(in_data), .in_ctrl(in_ctrl), .out_valid(out_valid),
        .out_field(out_field), .out_zero(out_zero)
    );

    function automatic logic [31:0] pack(input int s, input int l);
        return {16'd0, 8'(l), 8'(s)};
    endfunction

    function automatic logic [63:0] ref_ext(input logic [63:0] d,
                                            input logic [31:0] c, input logic w);
        int s = int'(c[7:0]);
        int l = int'(c[15:8]);
        int wd = w ? 64 : 32;
        logic [63:0] r = '0;
        for (int i = 0; i < 64; i++)
            if (i < l && s + i < wd) r[i] = d[s + i];
        return r;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, result is registered at the next rising edge,
    // sample at the falling edge that follows
    task automatic apply(input string tag, input logic [63:0] d,
                         input logic [31:0] c, input logic w);
        logic [63:0] exp;
        in_valid = 1'b1; in_data = d; in_ctrl = c; in_wide = w;
        exp = ref_ext(d, c, w);
        @(negedge clk);
        check({tag, " field"}, out_field, exp);
        check({tag, " zero R9"}, {63'd0, out_zero}, {63'd0, exp == 64'd0});
        check({tag, " valid R8"}, {63'd0, out_valid}, 64'd1);
    endtask

    task automatic t_reset;
        rst = 1'b1; in_valid = 1'b0; in_wide = 1'b1; in_data = '0; in_ctrl = '0;
        repeat (3) @(negedge clk);
        check("R1 valid", {63'd0, out_valid}, 64'd0);
        check("R1 field", out_field, 64'd0);
        check("R1 zero", {63'd0, out_zero}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after", {63'd0, out_valid}, 64'd0);
    endtask

    task automatic t_basic;
        apply("R2 0x50", 64'h50, pack(4, 4), 1'b1);
        check("R2 literal", out_field, 64'h5);
        apply("R2 mid", 64'hDEAD_BEEF_CAFE_F00D, pack(20, 16), 1'b1);
        apply("R2 full", 64'hDEAD_BEEF_CAFE_F00D, pack(0, 64), 1'b1);
        apply("R2 top bit", 64'h8000_0000_0000_0000, pack(63, 1), 1'b1);
        apply("R2 narrow", 64'h0000_0000_1234_5678, pack(8, 12), 1'b0);
    endtask

    task automatic t_start_oob;
        apply("R2 nonzero", 64'hFFFF_FFFF_FFFF_FFFF, pack(0, 8), 1'b1);
        apply("R3 wide 64", 64'hFFFF_FFFF_FFFF_FFFF, pack(64, 8), 1'b1);
        check("R3 wide literal", out_field, 64'd0);
        apply("R3 wide 255", 64'hFFFF_FFFF_FFFF_FFFF, pack(255, 255), 1'b1);
        apply("R3 narrow 32", 64'hFFFF_FFFF_FFFF_FFFF, pack(32, 8), 1'b0);
        check("R3 narrow literal", out_field, 64'd0);
    endtask

    task automatic t_len_zero;
        apply("R2 before", 64'h0F0F, pack(0, 4), 1'b1);
        apply("R4 len0", 64'hFFFF_FFFF_FFFF_FFFF, pack(5, 0), 1'b1);
        check("R4 zero flag", {63'd0, out_zero}, 64'd1);
    endtask

    task automatic t_overflow;
        apply("R5 wide", 64'hF000_0000_0000_0000, pack(60, 20), 1'b1);
        check("R5 wide literal", out_field, 64'hF);
        apply("R5 len255", 64'hFFFF_FFFF_FFFF_FFFF, pack(0, 255), 1'b1);
        check("R5 len255 literal", out_field, 64'hFFFF_FFFF_FFFF_FFFF);
        // clip at bit 31 and upper blanking on the same request
        apply("R5 R6 narrow", 64'hFFFF_FFFF_FFFF_FFFF, pack(28, 40), 1'b0);
        check("R5 narrow literal", out_field, 64'hF);
    endtask

    task automatic t_narrow;
        apply("R6 hi ignored", 64'hAAAA_AAAA_0000_0001, pack(0, 64), 1'b0);
        check("R6 literal", out_field, 64'h1);
        apply("R6 upper", 64'hFFFF_FFFF_FFFF_FFFF, pack(0, 200), 1'b0);
        check("R6 upper zero", {32'd0, out_field[63:32]}, 64'd0);
    endtask

    task automatic t_high_ctrl;
        apply("R7 hi ctrl", 64'h50, 32'hFFFF_0404, 1'b1);
        check("R7 literal", out_field, 64'h5);
        apply("R7 hi ctrl narrow", 64'h1234_5678, 32'hA5A5_1004, 1'b0);
    endtask

    task automatic t_hold;
        logic [63:0] held;
        apply("R10 load", 64'h00FF_00FF, pack(0, 16), 1'b1);
        held = out_field;
        in_valid = 1'b0; in_data = 64'hFFFF_FFFF_FFFF_FFFF; in_ctrl = pack(64, 0);
        @(negedge clk);
        check("R8 valid low", {63'd0, out_valid}, 64'd0);
        check("R10 field held", out_field, held);
        check("R10 zero held", {63'd0, out_zero}, 64'd0);
        @(negedge clk);
        check("R10 field held 2", out_field, held);
    endtask

    task automatic t_random;
        for (int n = 0; n < 400; n++) begin
            logic [63:0] d;
            logic [31:0] c;
            d = {$urandom(), $urandom()};
            c = $urandom();
            c[7:0]  = 8'($urandom_range(0, 80));
            c[15:8] = 8'($urandom_range(0, 80));
            apply("R2 R5 random", d, c, 1'($urandom_range(0, 1)));
        end
    endtask

    initial begin
        void'($urandom(17));
        t_reset();
        t_basic();
        t_start_oob();
        t_len_zero();
        t_overflow();
        t_narrow();
        t_high_ctrl();
        t_hold();
        t_random();
        in_valid = 1'b0;
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(200000 * 5);
        miscompares++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule